// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is an on-chip trace sink. While capture is on, every valid 32-bit word on the trace input goes into a circular RAM at the write pointer. The write pointer wraps at the end of the RAM, and a sticky flag records that old data has been overwritten. Words on the trace input are taken as already framed, so the block does no formatting of its own.

Software drives the block through a small register bus with single-cycle access. It can read the RAM size and the status, and it can set the read and write pointers. Two data registers advance the pointers on each access: one streams words out of the RAM, the other clears or preloads the RAM. Two optional stop conditions end a capture session. The first is a post-trigger word count. The second is a manual flush request, which the upstream path answers with an acknowledge.

Register read data is combinational on the current address. Writes, pointer steps and RAM stores take effect at the rising clock edge.

Top module: `trace_ring_buffer`

## Requirements
- R1: After reset, capture is off and both pointers are 0. The status register (0x00C) reads 0 and the flush control register (0x304) reads 0. The trigger count (0x01C) is 0, `flush_req` is low, and flush status (0x300) reads 2 (stopped).
- R2: The depth register at 0x004 reads the DEPTH parameter. A write to it has no effect.
- R3: Control register 0x020 bit 0 turns capture on or off. While capture is on, each cycle with `trc_valid` high stores `trc_data` at the write pointer (0x018). The pointer then advances by one and wraps from DEPTH-1 to 0. While capture is off, trace input leaves the write pointer unchanged.
- R4: Status bit 0 becomes 1 when the write pointer wraps from DEPTH-1 to 0. It stays 1 until software writes the write-pointer register.
- R5: A write to 0x024 stores the word at the write pointer and advances the pointer. If a trace word arrives in the same cycle, the bus write wins and the trace word is dropped.
- R6: A read of 0x010 returns the word at the read pointer (0x014) and then advances that pointer, wrapping at DEPTH-1. Software can write and read back both pointers.
- R7: A `trig_in` pulse during capture sets status bit 1. Capture must be on in that cycle. After the trigger cycle, each stored word lowers the trigger count by one, and the count stops at 0. If flush control bit 13 is set, no word is stored once the count is 0, and capture turns off. If bit 13 is clear, capture continues.
- R8: Writing 1 to flush control bit 6 raises `flush_req`, and bit 6 then reads 1. Both stay high until a cycle in which `flush_ack` is high, and they are low from the next cycle on.
- R9: If flush control bit 12 is set when a flush completes, capture turns off. If bit 12 is clear, capture stays on.
- R10: Flush status bit 1 follows capture one cycle late. It reads 1 one cycle after capture turns off, and 0 one cycle after capture turns on.
- R11: Flush control bits 0, 12 and 13 read back the values last written. All other bits of that register, apart from bit 6, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger event pulse |
| flush_req | output | 1 | Manual flush in progress |
| flush_ack | input | 1 | Upstream flush complete |

## Verification
A register write or a trace word is visible on the bus in the cycle after its clock edge. Reads are sampled combinationally before the edge that advances the read pointer. The formatter-stopped bit is the only result that lags by a second cycle. The bench reads it once directly after the control write and once a cycle later, and expects both values. The trigger stop and the flush handshake are driven to their exact terminal cycle. The bench then inspects the pointers, the count and the control bit, so that one extra or missing stored word changes a checked value.

// File: rtl/trace_ring_buffer.sv
module trace_ring_buffer #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  parameter int ABITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ABITS-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             trc_valid,
  input  logic [DW-1:0]    trc_data,
  input  logic             trig_in,
  output logic             flush_req,
  input  logic             flush_ack
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [ABITS-1:0] A_DEPTH = ABITS'('h004);
  localparam logic [ABITS-1:0] A_STAT  = ABITS'('h00C);
  localparam logic [ABITS-1:0] A_RDATA = ABITS'('h010);
  localparam logic [ABITS-1:0] A_RP    = ABITS'('h014);
  localparam logic [ABITS-1:0] A_WP    = ABITS'('h018);
  localparam logic [ABITS-1:0] A_TRG   = ABITS'('h01C);
  localparam logic [ABITS-1:0] A_CTL   = ABITS'('h020);
  localparam logic [ABITS-1:0] A_WDATA = ABITS'('h024);
  localparam logic [ABITS-1:0] A_FFSR  = ABITS'('h300);
  localparam logic [ABITS-1:0] A_FFCR  = ABITS'('h304);
  localparam int B_FMT = 0, B_FLUSH = 6, B_STOPFL = 12, B_STOPTRG = 13;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [DW-1:0] trig_cnt, ffcr_word;
  logic cap_en, full, trig_seen, fmt_stop;
  logic fmt_en, stop_fl, stop_trg, flush_q;

  wire wr = bus_sel & bus_wr;
  wire rd = bus_sel & ~bus_wr;
  wire wr_ctl  = wr && bus_addr == A_CTL;
  wire wr_wp   = wr && bus_addr == A_WP;
  wire wr_rp   = wr && bus_addr == A_RP;
  wire wr_trg  = wr && bus_addr == A_TRG;
  wire wr_ffcr = wr && bus_addr == A_FFCR;
  wire wr_ram  = wr && bus_addr == A_WDATA;
  wire rd_ram  = rd && bus_addr == A_RDATA;

  wire hold      = trig_seen && trig_cnt == '0 && stop_trg;
  wire trc_store = cap_en && trc_valid && !hold && !wr_ram && !wr_wp;
  wire mem_we    = wr_ram || trc_store;
  wire fl_done   = flush_q && flush_ack;
  wire [PW-1:0] wp_inc = (wp == LAST) ? '0 : wp + PW'(1);
  wire [PW-1:0] rp_inc = (rp == LAST) ? '0 : rp + PW'(1);

  assign flush_req = flush_q;

  always_ff @(posedge clk)
    if (mem_we) mem[wp] <= wr_ram ? bus_wdata : trc_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; trig_cnt <= '0;
      cap_en <= 1'b0; full <= 1'b0; trig_seen <= 1'b0; fmt_stop <= 1'b1;
      fmt_en <= 1'b0; stop_fl <= 1'b0; stop_trg <= 1'b0; flush_q <= 1'b0;
    end else begin
      if (wr_wp) wp <= bus_wdata[PW-1:0];
      else if (mem_we) wp <= wp_inc;

      if (wr_wp) full <= 1'b0;
      else if (mem_we && wp == LAST) full <= 1'b1;

      if (wr_rp) rp <= bus_wdata[PW-1:0];
      else if (rd_ram) rp <= rp_inc;

      if (wr_ctl) cap_en <= bus_wdata[0];
      else if (cap_en && hold) cap_en <= 1'b0;
      else if (fl_done && stop_fl) cap_en <= 1'b0;

      if (wr_ctl && bus_wdata[0]) trig_seen <= 1'b0;
      else if (cap_en && trig_in) trig_seen <= 1'b1;

      if (wr_trg) trig_cnt <= bus_wdata;
      else if (trc_store && trig_seen && trig_cnt != '0) trig_cnt <= trig_cnt - DW'(1);

      if (wr_ffcr) begin
        fmt_en   <= bus_wdata[B_FMT];
        stop_fl  <= bus_wdata[B_STOPFL];
        stop_trg <= bus_wdata[B_STOPTRG];
      end

      if (fl_done) flush_q <= 1'b0;
      else if (wr_ffcr && bus_wdata[B_FLUSH]) flush_q <= 1'b1;

      fmt_stop <= ~cap_en;
    end
  end

  always_comb begin
    ffcr_word = '0;
    ffcr_word[B_FMT]     = fmt_en;
    ffcr_word[B_FLUSH]   = flush_q;
    ffcr_word[B_STOPFL]  = stop_fl;
    ffcr_word[B_STOPTRG] = stop_trg;
  end

  always_comb begin
    case (bus_addr)
      A_DEPTH: bus_rdata = DW'(DEPTH);
      A_STAT:  bus_rdata = DW'({trig_seen, full});
      A_RDATA: bus_rdata = mem[rp];
      A_RP:    bus_rdata = DW'(rp);
      A_WP:    bus_rdata = DW'(wp);
      A_TRG:   bus_rdata = trig_cnt;
      A_CTL:   bus_rdata = DW'(cap_en);
      A_FFSR:  bus_rdata = DW'({fmt_stop, 1'b0});
      A_FFCR:  bus_rdata = ffcr_word;
      default: bus_rdata = '0;
    endcase
  end

  // R3
  wp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !wr_wp && !wr_ram) |=> $stable(wp));

  // R4
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !wr_wp) |=> full);

  // R6
  rp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ram && !wr_rp && rp != LAST) |=> rp == $past(rp) + PW'(1));

  // R7
  trig_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && hold && !wr_ctl) |=> !cap_en);

  // R8
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_q && !flush_ack) |=> flush_q);

  // R10
  fmt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> fmt_stop);
endmodule

// File: tb/trace_ring_buffer_tb_top.sv
`timescale 1ns/1ps
module trace_ring_buffer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, trc_valid = 0, trig_in = 0, flush_ack = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, trc_data = '0, bus_rdata;
  logic flush_req;
  int checks = 0, errors = 0;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  trace_ring_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trc_valid(trc_valid), .trc_data(trc_data), .trig_in(trig_in),
    .flush_req(flush_req), .flush_ack(flush_ack));

  // op(1: write, 0: read+compare), addr, data, expected
  localparam int NV = 18;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h004, 32'h0,         32'd64},        // R2
    {1'b1, 12'h004, 32'h5,         32'h0},         // R2 write ignored
    {1'b0, 12'h004, 32'h0,         32'd64},        // R2
    {1'b0, 12'h00C, 32'h0,         32'h0},         // R1
    {1'b0, 12'h300, 32'h0,         32'h2},         // R1
    {1'b1, 12'h018, 32'h3,         32'h0},         // R6
    {1'b1, 12'h024, 32'hAAAA0001,  32'h0},         // R5
    {1'b1, 12'h024, 32'hAAAA0002,  32'h0},         // R5
    {1'b0, 12'h018, 32'h0,         32'h5},         // R5
    {1'b1, 12'h014, 32'h3,         32'h0},         // R6
    {1'b0, 12'h010, 32'h0,         32'hAAAA0001},  // R6
    {1'b0, 12'h010, 32'h0,         32'hAAAA0002},  // R6
    {1'b0, 12'h014, 32'h0,         32'h5},         // R6
    {1'b1, 12'h304, 32'hFFFFFFBF,  32'h0},         // R11
    {1'b0, 12'h304, 32'h0,         32'h3001},      // R11
    {1'b1, 12'h304, 32'h0,         32'h0},         // R11
    {1'b1, 12'h01C, 32'h7,         32'h0},         // R7
    {1'b0, 12'h01C, 32'h0,         32'h7}          // R7
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(a, v);
    chk(tag, v, exp);
  endtask

  task automatic push(input logic [31:0] d, input logic t);
    @(negedge clk); trc_valid = 1; trc_data = d; trig_in = t;
    @(posedge clk); #1 trc_valid = 0; trig_in = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(2);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rd_chk("R1 ctrl", 12'h020, 0);
    rd_chk("R1 wp", 12'h018, 0);
    rd_chk("R1 rp", 12'h014, 0);
    rd_chk("R1 ffcr", 12'h304, 0);
    rd_chk("R1 trg", 12'h01C, 0);
    chk("R1 flush_req", 32'(flush_req), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr_reg(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd_reg(VEC[i][75:64], r);
        chk($sformatf("vector %0d (R1/R2/R5/R6/R7/R11)", i), r, VEC[i][31:0]);
      end
    end

    // R3 / R4 / R10: capture across the wrap
    wr_reg(12'h018, 62);
    wr_reg(12'h020, 1);
    rd_chk("R10 lag", 12'h300, 2);
    rd_chk("R10 running", 12'h300, 0);
    push(32'hD0, 0); push(32'hD1, 0); push(32'hD2, 0);
    rd_chk("R3 wp wrap", 12'h018, 1);
    rd_chk("R4 full set", 12'h00C, 1);
    wr_reg(12'h020, 0);
    idle(1);
    rd_chk("R10 stopped", 12'h300, 2);
    push(32'hD3, 0);
    rd_chk("R3 ignored when off", 12'h018, 1);
    wr_reg(12'h014, 62);
    rd_chk("R3 word 62", 12'h010, 32'hD0);
    rd_chk("R3 word 63", 12'h010, 32'hD1);
    rd_chk("R6 word 0 after wrap", 12'h010, 32'hD2);
    rd_chk("R6 rp wrap", 12'h014, 1);
    rd_chk("R4 full holds", 12'h00C, 1);
    wr_reg(12'h018, 0);
    rd_chk("R4 cleared by wp write", 12'h00C, 0);

    // R5: bus RAM write beats a trace word in the same cycle
    wr_reg(12'h018, 10);
    wr_reg(12'h020, 1);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 12'h024; bus_wdata = 32'hB0B0;
    trc_valid = 1; trc_data = 32'hCCCC;
    @(posedge clk); #1 bus_sel = 0; bus_wr = 0; trc_valid = 0;
    wr_reg(12'h020, 0);
    rd_chk("R5 single advance", 12'h018, 11);
    wr_reg(12'h014, 10);
    rd_chk("R5 bus word kept", 12'h010, 32'hB0B0);

    // R7: stop on trigger count
    wr_reg(12'h018, 0);
    wr_reg(12'h01C, 2);
    wr_reg(12'h304, 32'h2000);
    wr_reg(12'h020, 1);
    push(32'hE0, 1); push(32'hE1, 0); push(32'hE2, 0); push(32'hE3, 0); push(32'hE4, 0);
    rd_chk("R7 wp after stop", 12'h018, 3);
    rd_chk("R7 capture off", 12'h020, 0);
    rd_chk("R7 trig status", 12'h00C, 2);
    rd_chk("R7 count zero", 12'h01C, 0);
    wr_reg(12'h014, 0);
    rd_chk("R7 word 0", 12'h010, 32'hE0);
    rd_chk("R7 word 1", 12'h010, 32'hE1);
    rd_chk("R7 word 2", 12'h010, 32'hE2);

    // R7: without stop-on-trigger capture continues
    wr_reg(12'h304, 0);
    wr_reg(12'h018, 0);
    wr_reg(12'h01C, 1);
    wr_reg(12'h020, 1);
    push(32'hF0, 1); push(32'hF1, 0); push(32'hF2, 0); push(32'hF3, 0);
    rd_chk("R7 no stop wp", 12'h018, 4);
    rd_chk("R7 no stop ctrl", 12'h020, 1);
    rd_chk("R7 count floor", 12'h01C, 0);

    // R8 / R9: manual flush with stop on completion
    wr_reg(12'h304, 32'h1040);
    rd_chk("R8 bit6 pending", 12'h304, 32'h1040);
    chk("R8 flush_req high", 32'(flush_req), 1);
    idle(3);
    chk("R8 flush_req held", 32'(flush_req), 1);
    @(negedge clk); flush_ack = 1;
    @(posedge clk); #1 flush_ack = 0;
    rd_chk("R8 bit6 cleared", 12'h304, 32'h1000);
    chk("R8 flush_req low", 32'(flush_req), 0);
    rd_chk("R9 capture stopped", 12'h020, 0);

    // R9: flush without stop keeps capture
    wr_reg(12'h020, 1);
    wr_reg(12'h304, 32'h0040);
    @(negedge clk); flush_ack = 1;
    @(posedge clk); #1 flush_ack = 0;
    rd_chk("R9 capture kept", 12'h020, 1);
    rd_chk("R8 done", 12'h304, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule